// File: doc/BRIEF.md
# Zero-Fill UART Byte Transmitter

This block turns bytes handed over by a host into asynchronous serial frames on one output wire. A byte is taken through a valid/ready handshake. It is then placed, with its framing bits, into a parallel-load shift register. An internal clock divider produces a one-cycle bit tick, and each tick moves one bit from the register into a registered line flip-flop that drives the wire.

The block has no bit counter. Each shift fills the vacated top position with a zero, so the register empties as the frame goes out. Once the last stop bit has left, the register holds all zeros. The block then keeps that stop bit on the wire for one more full bit period and ends the frame. In the last cycle of the frame it raises a one-cycle completion pulse, and after that it can accept the next byte.

A frame is one low start bit, eight data bits sent least significant bit first, and two high stop bits. Each bit lasts `BIT_DIV` clock cycles.

Top module: `uart_tx_zf`

## Requirements
- R1: While `rst` is high at a clock edge, the block is reset. In the cycle after that edge, `txd` is 1, `tx_ready` is 1 and `tx_busy` is 0.
- R2: Whenever `tx_busy` is 0, `txd` is 1.
- R3: A byte is accepted at a rising edge where `tx_valid` and `tx_ready` are both 1. From that edge, `txd` is 0 (the start bit) for exactly `BIT_DIV` cycles, and `tx_busy` is 1.
- R4: After the start bit, the eight data bits follow in order bit 0 first through bit 7 last. Each lasts exactly `BIT_DIV` cycles, and `txd` changes only at bit boundaries.
- R5: After bit 7 come two stop bits at 1, each lasting `BIT_DIV` cycles. Whenever the frame register is empty during a frame, `txd` is 1.
- R6: `tx_ready` is 1 only while `tx_busy` is 0. A byte offered while busy is not taken: it never appears on `txd`, and it does not disturb the frame in flight.
- R7: `tx_busy` stays 1 for exactly 11*`BIT_DIV` cycles per frame. `tx_done` is 1 for exactly one cycle, the last cycle of the frame. In the next cycle, `tx_busy` is 0 and `tx_ready` is 1.
- R8: If `tx_valid` is held high with a new byte, the next start bit begins exactly 11*`BIT_DIV`+1 cycles after the previous one began. This is one idle-high cycle between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_byte | input | DATA_W | Byte to send |
| tx_valid | input | 1 | Host offers `tx_byte` |
| tx_ready | output | 1 | Block can take a byte this cycle |
| txd | output | 1 | Serial line, high when idle |
| tx_busy | output | 1 | A frame is in progress |
| tx_done | output | 1 | One-cycle pulse in the last cycle of a frame |

## Verification
The assertions assume that `rst` is held high from time zero until the first edges have passed. They also assume that `tx_valid` and `tx_byte` change only away from the rising edge, so a byte is accepted at a single, clean edge. The bench drives every input on the falling edge. It releases reset only after several cycles. The bench also offers bytes during busy periods, but only while `tx_busy` is high, so that an ignored offer cannot turn into an acceptance at the end of the frame.

// File: rtl/uart_tx_zf_pkg.sv
package uart_tx_zf_pkg;
  localparam logic LINE_IDLE  = 1'b1;
  localparam logic LVL_START  = 1'b0;
  localparam logic LVL_STOP   = 1'b1;

  // total bits on the wire for one frame
  function automatic int frame_bits(input int data_w, input int stop_w);
    return 1 + data_w + stop_w;
  endfunction

  // width of a counter that counts 0 .. n-1
  function automatic int count_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/uart_tx_zf_baud.sv
module uart_tx_zf_baud
  import uart_tx_zf_pkg::*;
#(
  parameter int BIT_DIV = 868
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic tick
);
  localparam int CW = count_width(BIT_DIV);
  localparam logic [CW-1:0] LAST = CW'(BIT_DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (tick)      cnt <= '0;
    else                cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/uart_tx_zf_shift.sv
module uart_tx_zf_shift
  import uart_tx_zf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int STOP_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              tick,
  output logic              line,
  output logic              run,
  output logic              drained,
  output logic              finish
);
  localparam int FW = frame_bits(DATA_W, STOP_W);

  function automatic logic [FW-1:0] pack_frame(input logic [DATA_W-1:0] d);
    return {{STOP_W{LVL_STOP}}, d, LVL_START};
  endfunction

  logic [FW-1:0] sr;
  logic [FW-1:0] fresh;

  assign fresh   = pack_frame(load_data);
  assign drained = (sr == '0);
  assign finish  = run && tick && drained;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr   <= '0;
      line <= LINE_IDLE;
      run  <= 1'b0;
    end else if (load) begin
      // loading counts as the first shift: start bit goes straight to the line
      line <= fresh[0];
      sr   <= {1'b0, fresh[FW-1:1]};
      run  <= 1'b1;
    end else if (run && tick) begin
      if (drained) begin
        run  <= 1'b0;
        line <= LINE_IDLE;
      end else begin
        line <= sr[0];
        sr   <= {1'b0, sr[FW-1:1]};
      end
    end else if (!run) begin
      line <= LINE_IDLE;
    end
  end
endmodule

// File: rtl/uart_tx_zf.sv
module uart_tx_zf
  import uart_tx_zf_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int STOP_W  = 2,
  parameter int BIT_DIV = 868
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              txd,
  output logic              tx_busy,
  output logic              tx_done
);
  logic accept;
  logic bit_tick;
  logic sr_drained;
  logic frame_end;
  logic running;

  assign tx_ready = !running;
  assign accept   = tx_valid && !running;
  assign tx_busy  = running;
  assign tx_done  = frame_end;

  uart_tx_zf_baud #(.BIT_DIV(BIT_DIV)) u_baud (
    .clk     (clk),
    .rst     (rst),
    .restart (accept),
    .tick    (bit_tick)
  );

  uart_tx_zf_shift #(.DATA_W(DATA_W), .STOP_W(STOP_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .load      (accept),
    .load_data (tx_byte),
    .tick      (bit_tick),
    .line      (txd),
    .run       (running),
    .drained   (sr_drained),
    .finish    (frame_end)
  );
endmodule

// File: rtl/uart_tx_zf_chk.sv
module uart_tx_zf_chk (
  input logic clk,
  input logic rst,
  input logic accept,
  input logic bit_tick,
  input logic sr_drained,
  input logic txd,
  input logic tx_busy,
  input logic tx_ready,
  input logic tx_done
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (txd && tx_ready && !tx_busy));

  // R2
  idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    !tx_busy |-> txd);

  // R3
  start_low_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> (!txd && tx_busy));

  // R4
  bit_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_busy && $past(tx_busy) && !$past(bit_tick)) |-> $stable(txd));

  // R5
  drained_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_busy && sr_drained) |-> txd);

  // R6
  ready_excl_chk: assert property (@(posedge clk) disable iff (rst)
    tx_busy |-> !tx_ready);

  // R7
  done_release_chk: assert property (@(posedge clk) disable iff (rst)
    tx_done |=> (!tx_busy && tx_ready && !tx_done));
endmodule

bind uart_tx_zf uart_tx_zf_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .accept     (accept),
  .bit_tick   (bit_tick),
  .sr_drained (sr_drained),
  .txd        (txd),
  .tx_busy    (tx_busy),
  .tx_ready   (tx_ready),
  .tx_done    (tx_done)
);

// File: tb/tb_uart_tx_zf.sv
module tb_uart_tx_zf;
  localparam int CLK_PERIOD = 10;
  localparam int BIT_DIV    = 4;
  localparam int FRAME_CYC  = 11 * BIT_DIV;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] tx_byte = '0;
  logic       tx_valid = 1'b0;
  logic       tx_ready, txd, tx_busy, tx_done;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int frames_sent = 0;
  int frames_seen = 0;
  logic [7:0] exp_q[$];
  bit         gap_q[$];

  uart_tx_zf #(.DATA_W(8), .STOP_W(2), .BIT_DIV(BIT_DIV)) dut (
    .clk(clk), .rst(rst), .tx_byte(tx_byte), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .txd(txd), .tx_busy(tx_busy), .tx_done(tx_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc, WATCHDOG);
      summary();
    end
  end

  // driver: push the expectation, then offer the byte until it is taken
  task automatic send_frame(input logic [7:0] d, input bit b2b);
    exp_q.push_back(d);
    gap_q.push_back(b2b);
    frames_sent++;
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_byte  = d;
    tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  // offer a byte only while busy: must be ignored (R6)
  task automatic poke_busy(input logic [7:0] d, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (tx_busy) begin
        tx_byte  = d;
        tx_valid = 1'b1;
        check(tx_ready == 1'b0, "R6 ready while busy", tx_ready, 0);
      end else begin
        tx_valid = 1'b0;
      end
    end
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  // monitor: detect start, sample each bit at its first and last cycle
  initial begin
    logic prev_line;
    int   last_start;
    prev_line  = 1'b1;
    last_start = -1000;
    @(negedge clk);
    while (rst) @(negedge clk);
    forever begin
      @(negedge clk);
      if (!txd && prev_line) begin
        logic [7:0] want, got;
        bit         b2b;
        int         here;
        here = cyc;
        frames_seen++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R6 unexpected frame", 1, 0);
          want = '0;
          b2b  = 1'b0;
        end else begin
          want = exp_q.pop_front();
          b2b  = gap_q.pop_front();
        end
        if (b2b) check(here - last_start == FRAME_CYC + 1, "R8 back-to-back spacing",
                       here - last_start, FRAME_CYC + 1);
        last_start = here;
        check(tx_busy == 1'b1 && tx_ready == 1'b0, "R3 busy after accept", {tx_busy, tx_ready}, 2'b10);
        got = '0;
        for (int off = 0; off <= FRAME_CYC; off++) begin
          if (off > 0) @(negedge clk);
          if (off < FRAME_CYC) begin
            int   k, r;
            logic bexp;
            k = off / BIT_DIV;
            r = off % BIT_DIV;
            bexp = (k == 0) ? 1'b0 : (k <= 8) ? want[k-1] : 1'b1;
            if (r == 0 && k >= 1 && k <= 8) got[k-1] = txd;
            if (r == 0 || r == BIT_DIV - 1) begin
              if (k == 0)      check(txd == bexp, "R3 start bit", txd, bexp);
              else if (k <= 8) check(txd == bexp, "R4 data bit timing", txd, bexp);
              else             check(txd == bexp, "R5 stop bit", txd, bexp);
            end
            if (off == FRAME_CYC - 1)
              check(tx_done == 1'b1 && tx_busy == 1'b1, "R7 done in last cycle", {tx_done, tx_busy}, 2'b11);
            else
              if (r == 0) check(tx_done == 1'b0, "R7 done early", tx_done, 0);
          end else begin
            check(tx_busy == 1'b0 && tx_ready == 1'b1 && tx_done == 1'b0, "R7 release after frame",
                  {tx_busy, tx_ready, tx_done}, 3'b010);
            check(txd == 1'b1, "R2 idle high after frame", txd, 1);
          end
        end
        check(got == want, "R4 byte LSB first", got, want);
      end
      prev_line = txd;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check(txd == 1'b1 && tx_ready == 1'b1 && tx_busy == 1'b0, "R1 in reset",
          {txd, tx_ready, tx_busy}, 3'b110);
    rst = 1'b0;
    @(negedge clk);
    check(txd == 1'b1 && tx_ready == 1'b1 && tx_busy == 1'b0 && tx_done == 1'b0, "R1 after reset",
          {txd, tx_ready, tx_busy, tx_done}, 4'b1100);
    repeat (5) @(negedge clk);
    check(txd == 1'b1, "R2 idle line", txd, 1);

    send_frame(8'h00, 1'b0);
    send_frame(8'hFF, 1'b0);
    send_frame(8'h55, 1'b0);
    poke_busy(8'hE7, 10);
    send_frame(8'hA5, 1'b0);
    poke_busy(8'h18, 6);
    send_frame(8'h01, 1'b0);
    send_frame(8'h80, 1'b0);
    // valid held: the second of each pair rides straight after the first
    send_frame(8'h3C, 1'b0);
    send_frame(8'hC3, 1'b1);
    send_frame(8'h96, 1'b1);

    while (exp_q.size() != 0) @(negedge clk);
    repeat (FRAME_CYC + 8) @(negedge clk);
    check(frames_seen == frames_sent, "R6 frame count", frames_seen, frames_sent);
    check(txd == 1'b1 && tx_busy == 1'b0, "R2 final idle", {txd, tx_busy}, 2'b10);
    summary();
  end
endmodule